// File: doc/BRIEF.md
# Six-Pin General-Purpose Port with Register Access

This block is a six-pin bidirectional port that a small processor controls through a simple register interface. Software sets a direction bit per pin and loads an output latch. It selects pins as analog to take them out of digital reads, and it enables weak pull-ups per pin under one global disable. The block drives an output-enable, an output value and a pull-up request for each pad. It brings the pad levels in through a two-stage synchronizer.

Pin 3 can only be an input. A configuration input can give it to a reset function. When that is selected, pin 3 reads as 0 and its pull-up is on with no register involved. A read of the port register returns the synchronized pad levels and never the latch. A read-modify-write of the port therefore writes sampled pad levels back into the latch.

Top module: `gpio_port6`

## Requirements
- R1: After reset, the direction register (address 1) and the analog-select register (address 3) read 0x3F. The option register (address 4) reads 0x80. The pull-up enable register (address 2) reads 0x00. pin_oe, pin_out and pin_pu are all 0.
- R2: pin_oe[i] is 1 exactly when direction bit i is 0, except for pin 3. pin_out carries the output latch, and it changes on the clock edge that takes the write.
- R3: Pin 3 is input-only. Its direction bit reads 1 whatever is written, pin_oe[3] stays 0 and pin_out[3] stays 0.
- R4: A read of the port register (address 0) returns pin_in as seen through two flops. A pad change shows in rdata after the second rising edge, not after the first. It is never the latch value. Bits 7:6 read 0.
- R5: A write to address 0 loads wdata[5:0] into the output latch. Bit 3 is held at 0.
- R6: A pin whose analog-select bit is 1 reads 0 at address 0. Its direction bit still sets pin_oe.
- R7: While pin3_rst_sel is 1, bit 3 of the port register reads 0 and pin_pu[3] is 1. While it is 0, pin_pu[3] is 0.
- R8: For pins other than 3, pin_pu[i] is 1 only when pull-up enable bit i is 1, direction bit i is 1 (input), and the global disable is 0. Bit 3 of the pull-up enable register reads 0.
- R9: Bit 7 of the option register is the global pull-up disable. It is 1 after reset, and its other bits read 0.
- R10: Addresses 5 to 7 read 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Single-cycle write strobe |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Combinational read data for addr |
| pin3_rst_sel | input | 1 | Pin 3 is given to the reset function |
| pin_in | input | 6 | Pad input levels, asynchronous |
| pin_oe | output | 6 | Pad output enable per pin |
| pin_out | output | 6 | Pad output value per pin |
| pin_pu | output | 6 | Weak pull-up request per pin |

## Verification
A write to the port latch and a read of the same port register can fall in the same cycle while the pads hold different values. The bench loads all ones into the latch while the pads carry another pattern. It reads address 0 straight after and expects the pad pattern, while pin_out shows the new latch. A second overlap arises when a direction write or an option write lands while pull-ups are enabled. In the cycle after that write, pin_pu must drop or rise at once, following the new direction and disable state.

// File: rtl/gpio_port6.sv
module gpio_port6 #(
  parameter int AW = 3,
  parameter int DW = 8,
  parameter int NP = 6,
  parameter int IN_ONLY = 3,
  parameter logic [NP-1:0] DIR_RST = '1,
  parameter logic [NP-1:0] ANA_RST = '1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic          pin3_rst_sel,
  input  logic [NP-1:0] pin_in,
  output logic [NP-1:0] pin_oe,
  output logic [NP-1:0] pin_out,
  output logic [NP-1:0] pin_pu
);
  localparam logic [NP-1:0] SOLO    = NP'(1) << IN_ONLY;
  localparam logic [NP-1:0] IO_MASK = ~SOLO;
  localparam logic [AW-1:0] A_PORT = AW'(0);
  localparam logic [AW-1:0] A_DIR  = AW'(1);
  localparam logic [AW-1:0] A_PU   = AW'(2);
  localparam logic [AW-1:0] A_ANA  = AW'(3);
  localparam logic [AW-1:0] A_OPT  = AW'(4);

  logic [NP-1:0] dir_q, lat_q, wpu_q, ana_q, s1_q, s2_q;
  logic          pu_off_q;
  logic [NP-1:0] port_view;
  logic          unused_bits;

  assign unused_bits = ^wdata[DW-2:NP];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q    <= DIR_RST | SOLO;
      lat_q    <= '0;
      wpu_q    <= '0;
      ana_q    <= ANA_RST;
      pu_off_q <= 1'b1;
      s1_q     <= '0;
      s2_q     <= '0;
    end else begin
      s1_q <= pin_in;
      s2_q <= s1_q;
      if (wr_en) begin
        case (addr)
          A_PORT: lat_q    <= wdata[NP-1:0] & IO_MASK;
          A_DIR:  dir_q    <= wdata[NP-1:0] | SOLO;
          A_PU:   wpu_q    <= wdata[NP-1:0] & IO_MASK;
          A_ANA:  ana_q    <= wdata[NP-1:0];
          A_OPT:  pu_off_q <= wdata[DW-1];
          default: ;
        endcase
      end
    end
  end

  assign port_view = s2_q & ~ana_q & ~(pin3_rst_sel ? SOLO : '0);

  assign pin_oe  = ~dir_q & IO_MASK;
  assign pin_out = lat_q;
  assign pin_pu  = (wpu_q & dir_q & {NP{~pu_off_q}}) | (pin3_rst_sel ? SOLO : '0);

  always_comb begin
    case (addr)
      A_PORT:  rdata = DW'(port_view);
      A_DIR:   rdata = DW'(dir_q);
      A_PU:    rdata = DW'(wpu_q);
      A_ANA:   rdata = DW'(ana_q);
      A_OPT:   rdata = {pu_off_q, {(DW-1){1'b0}}};
      default: rdata = '0;
    endcase
  end
endmodule

module gpio_port6_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [2:0] addr,
  input logic [7:0] wdata,
  input logic [7:0] rdata,
  input logic       pin3_rst_sel,
  input logic [5:0] pin_oe,
  input logic [5:0] pin_out,
  input logic [5:0] pin_pu
);
  a_r3_pin3_never_driven: assert property (@(posedge clk) disable iff (!rst_n)
    !pin_oe[3] && !pin_out[3]);

  a_r2_oe_after_dir_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 3'd1) |=> pin_oe == (~$past(wdata[5:0]) & 6'h37));

  a_r5_latch_load: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 3'd0) |=> pin_out == ($past(wdata[5:0]) & 6'h37));

  a_r8_no_pullup_on_driven_pin: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_pu & pin_oe) == 6'h00);

  a_r4_upper_port_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == 3'd0) |-> rdata[7:6] == 2'b00);

  a_r7_pin3_pullup: assert property (@(posedge clk) disable iff (!rst_n)
    pin_pu[3] == pin3_rst_sel);

  a_r10_unmapped_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (addr > 3'd4) |-> rdata == 8'h00);
endmodule

bind gpio_port6 gpio_port6_chk chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .rdata(rdata), .pin3_rst_sel(pin3_rst_sel), .pin_oe(pin_oe),
  .pin_out(pin_out), .pin_pu(pin_pu)
);

// File: tb/gpio_port6_tb_top.sv
`timescale 1ns/1ps
module gpio_port6_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       pin3_rst_sel = 1'b0;
  logic [5:0] pin_in = '0;
  logic [5:0] pin_oe, pin_out, pin_pu;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  typedef struct {
    int         kind;
    logic [7:0] exp;
    string      tag;
  } item_t;
  item_t sb_q[$];
  event  sample_ev;

  always #4 clk = ~clk;

  gpio_port6 dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .pin3_rst_sel(pin3_rst_sel), .pin_in(pin_in),
    .pin_oe(pin_oe), .pin_out(pin_out), .pin_pu(pin_pu)
  );

  initial begin
    forever begin
      @(sample_ev);
      while (sb_q.size() > 0) begin
        item_t it;
        logic [7:0] act;
        it = sb_q.pop_front();
        case (it.kind)
          0: act = rdata;
          1: act = {2'b00, pin_oe};
          2: act = {2'b00, pin_out};
          default: act = {2'b00, pin_pu};
        endcase
        n_chk++;
        if (act !== it.exp) begin
          n_bad++;
          $display("FAIL %s: actual 0x%02h expected 0x%02h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic expect_out(input int kind, input logic [2:0] a,
                            input logic [7:0] e, input string tag);
    item_t it;
    addr = a;
    #1;
    it.kind = kind; it.exp = e; it.tag = tag;
    sb_q.push_back(it);
    ->sample_ev;
    #1;
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    expect_out(0, 3'd1, 8'h3F, "R1 dir reset");
    expect_out(0, 3'd3, 8'h3F, "R1 analog reset");
    expect_out(0, 3'd4, 8'h80, "R1 option reset");
    expect_out(0, 3'd2, 8'h00, "R1 pull enable reset");
    expect_out(1, 3'd0, 8'h00, "R1 oe reset");
    expect_out(2, 3'd0, 8'h00, "R1 out reset");
    expect_out(3, 3'd0, 8'h00, "R1 pu reset");

    // R10 unmapped addresses
    wr(3'd5, 8'hFF); wr(3'd6, 8'h00); wr(3'd7, 8'h7F);
    @(negedge clk);
    expect_out(0, 3'd5, 8'h00, "R10 unmapped read");
    expect_out(0, 3'd1, 8'h3F, "R10 dir untouched");
    expect_out(0, 3'd3, 8'h3F, "R10 analog untouched");
    expect_out(0, 3'd4, 8'h80, "R10 option untouched");
    expect_out(0, 3'd2, 8'h00, "R10 pull untouched");
    expect_out(2, 3'd0, 8'h00, "R10 latch untouched");

    // R6 clear analog selects, R4 synchronizer latency
    wr(3'd3, 8'h00);
    expect_out(0, 3'd3, 8'h00, "R6 analog cleared");
    pin_in = 6'b101010;
    @(negedge clk);
    expect_out(0, 3'd0, 8'h00, "R4 one edge not yet visible");
    @(negedge clk);
    expect_out(0, 3'd0, 8'h2A, "R4 two edges visible");

    // R5 latch write overlapping port read; R4 read is not latch
    wr(3'd0, 8'hFF);
    expect_out(2, 3'd0, 8'h37, "R5 latch loaded pin3 held 0");
    expect_out(0, 3'd0, 8'h2A, "R4 read shows pads not latch");

    // R2/R3 direction
    wr(3'd1, 8'h00);
    expect_out(0, 3'd1, 8'h08, "R3 pin3 dir reads 1");
    expect_out(1, 3'd0, 8'h37, "R2 outputs enabled R3 pin3 off");
    wr(3'd1, 8'h0F);
    expect_out(0, 3'd1, 8'h0F, "R2 dir readback");
    expect_out(1, 3'd0, 8'h30, "R2 partial outputs");

    // R8/R9 pull-ups
    wr(3'd2, 8'hFF);
    expect_out(0, 3'd2, 8'h37, "R8 pull enable bit3 reads 0");
    expect_out(3, 3'd0, 8'h00, "R9 global disable blocks pulls");
    wr(3'd4, 8'h00);
    expect_out(0, 3'd4, 8'h00, "R9 disable cleared");
    expect_out(3, 3'd0, 8'h07, "R8 pulls only on inputs");
    wr(3'd4, 8'h7F);
    expect_out(0, 3'd4, 8'h00, "R9 low bits read 0");
    wr(3'd4, 8'hFF);
    expect_out(0, 3'd4, 8'h80, "R9 disable set again");
    expect_out(3, 3'd0, 8'h00, "R9 pulls off");
    wr(3'd4, 8'h00);

    // R6 analog masking, driver still under direction
    wr(3'd3, 8'h03);
    expect_out(0, 3'd0, 8'h28, "R6 analog pins read 0");
    expect_out(1, 3'd0, 8'h30, "R6 oe unchanged by analog");
    wr(3'd1, 8'h3C);
    expect_out(1, 3'd0, 8'h03, "R6 analog pins still driven");
    expect_out(3, 3'd0, 8'h34, "R8 pulls follow new direction");

    // R7 reset function on pin 3
    @(negedge clk);
    pin3_rst_sel = 1'b1;
    expect_out(0, 3'd0, 8'h20, "R7 pin3 reads 0");
    expect_out(3, 3'd0, 8'h3C, "R7 pin3 pull on");
    pin3_rst_sel = 1'b0;
    expect_out(0, 3'd0, 8'h28, "R7 pin3 visible again");
    expect_out(3, 3'd0, 8'h34, "R7 pin3 pull off");

    // R5 latch cleared, upper write bits ignored
    wr(3'd0, 8'hC1);
    expect_out(2, 3'd0, 8'h01, "R5 latch low bits only");

    @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule